// File: doc/BRIEF.md
# Indirect PHY Parameter Register Port

This block sits on the PHY side of a two-phase, strobed indirect write protocol. Software writes one 32-bit configuration word through a plain write strobe. The same upper bits of that word carry either a register number or a data byte. The phase is given only by which of two enable bits goes from 0 to 1 compared with the previous written word.

In the address phase, a rising address-enable bit latches a 12-bit register number. In the data phase, a rising data-enable bit commits a byte into the byte-wide parameter file entry that the latched number selects. The parameter file has 16 entries. Four of its fields drive PHY control outputs: the RX sync check mode, the RX sync length, the low-speed slew rate and the full/low-speed driver slew. The block has no valid/ready stream: the write strobe is accepted on every cycle it is high, and the block never applies back-pressure.

Top module: `phy_param_port`

## Requirements
- R1: After reset, every parameter file entry is zero, all four field outputs are 0, and no register number is held.
- R2: A write whose bit 28 is 1, when bit 28 of the previous written word was 0, latches bits 27:16 as the register number.
- R3: A write whose bit 29 is 1, when bit 29 of the previous written word was 0, stores bits 23:16 into the entry selected by the latched register number. The new value shows on the outputs from the cycle after the write.
- R4: A write that keeps an enable bit at 1 when it was already 1 does not latch again and does not commit again.
- R5: A data commit made while no register number has been latched since reset leaves every entry unchanged.
- R6: A data commit to a latched register number of 16 or more changes no entry. Numbers do not wrap onto a lower entry.
- R7: When bits 28 and 29 both rise in the same write, the register number is latched and the data byte is discarded.
- R8: rx_sync_chk is entry 0 bit 5, rx_sync_len is entry 1 bits 1:0, ls_slew is entry 10 bit 6, and fsls_drv is entry 10 bit 5.
- R9: A latched register number stays in force across any number of data commits until the next address phase.
- R10: Cycles with cfg_we low have no effect. Edge detection compares each write with the previous written word, not with the data bus on idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word written |
| rx_sync_chk | output | 1 | RX sync check mode |
| rx_sync_len | output | 2 | RX sync length select |
| ls_slew | output | 1 | Low-speed slew rate select |
| fsls_drv | output | 1 | Full/low-speed driver slew select |

## Verification
The bench sweeps register numbers 0 to 19 against several byte patterns. It checks that numbers 16 to 19 never alias onto entries 0 to 3; a design that truncated the number would flip rx_sync_chk or rx_sync_len. It also targets four other errors:
- An enable held high on a second write must not commit again; a level-sensitive design would overwrite the entry.
- A data phase sent before any address must change nothing; a design that defaults to entry 0 would set the sync mode.
- When both enables rise in one write, the byte must not land in the entry.
- A bus that changes while the strobe is low must not move the edge reference, or the next write's edge would be missed or invented.

// File: rtl/phy_param_pkg.sv
package phy_param_pkg;
  localparam int CFG_W    = 32;
  localparam int FIELD_LSB = 16;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 8;
  localparam int AEN_BIT  = 28;
  localparam int DEN_BIT  = 29;

  localparam int IDX_SYNC_MODE = 0;
  localparam int BIT_SYNC_MODE = 5;
  localparam int IDX_SYNC_LEN  = 1;
  localparam int IDX_SLEW      = 10;
  localparam int BIT_LS_SLEW   = 6;
  localparam int BIT_FSLS_DRV  = 5;

  typedef struct packed {
    logic              addr_rise;
    logic              data_rise;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cfg_event_t;
endpackage

// File: rtl/cfg_edge_detect.sv
module cfg_edge_detect
  import phy_param_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_event_t       ev,
  output logic             aen_lvl,
  output logic             den_lvl
);
  logic aen_q, den_q;

  // reference levels follow written words only, never the idle bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aen_q <= 1'b0;
      den_q <= 1'b0;
    end else if (we) begin
      aen_q <= wdata[AEN_BIT];
      den_q <= wdata[DEN_BIT];
    end
  end

  logic a_rise, d_rise;
  always_comb begin
    a_rise = we & wdata[AEN_BIT] & ~aen_q;
    // a simultaneous address edge wins; the byte is dropped
    d_rise = we & wdata[DEN_BIT] & ~den_q & ~a_rise;
    ev.addr_rise = a_rise;
    ev.data_rise = d_rise;
    ev.addr      = wdata[FIELD_LSB +: ADDR_W];
    ev.data      = wdata[FIELD_LSB +: DATA_W];
  end

  assign aen_lvl = aen_q;
  assign den_lvl = den_q;

  a_r10_idle_keeps_ref: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(aen_lvl) && $stable(den_lvl)));
endmodule

// File: rtl/param_addr_latch.sv
module param_addr_latch
  import phy_param_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_rise,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_rise,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_vld,
  output logic              commit
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      addr_vld <= 1'b0;
    end else if (addr_rise) begin
      addr_q   <= addr_in;
      addr_vld <= 1'b1;
    end
  end

  assign commit = data_rise & addr_vld & (addr_q < LIMIT);

  a_r2_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    addr_rise |=> (addr_vld && addr_q == $past(addr_in)));
  a_r9_addr_persists: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_rise |=> $stable(addr_q));
endmodule

// File: rtl/param_regfile.sv
module param_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= '0;
      else if (hit) regs[i] <= wr_data;
    end
  end

  a_r3_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/param_field_map.sv
module param_field_map
  import phy_param_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  output logic                            rx_sync_chk,
  output logic [1:0]                      rx_sync_len,
  output logic                            ls_slew,
  output logic                            fsls_drv
);
  if (IDX_SYNC_MODE < NUM_REGS) begin : g_mode
    assign rx_sync_chk = regs[IDX_SYNC_MODE][BIT_SYNC_MODE];
  end else begin : g_mode_none
    assign rx_sync_chk = 1'b0;
  end

  if (IDX_SYNC_LEN < NUM_REGS) begin : g_len
    assign rx_sync_len = regs[IDX_SYNC_LEN][1:0];
  end else begin : g_len_none
    assign rx_sync_len = 2'b00;
  end

  if (IDX_SLEW < NUM_REGS) begin : g_slew
    assign ls_slew  = regs[IDX_SLEW][BIT_LS_SLEW];
    assign fsls_drv = regs[IDX_SLEW][BIT_FSLS_DRV];
  end else begin : g_slew_none
    assign ls_slew  = 1'b0;
    assign fsls_drv = 1'b0;
  end
endmodule

// File: rtl/phy_param_port.sv
module phy_param_port
  import phy_param_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic        rx_sync_chk,
  output logic [1:0]  rx_sync_len,
  output logic        ls_slew,
  output logic        fsls_drv
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  cfg_event_t        ev;
  logic              aen_lvl, den_lvl;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_vld, commit;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  cfg_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .ev(ev), .aen_lvl(aen_lvl), .den_lvl(den_lvl)
  );

  param_addr_latch #(.NUM_REGS(NUM_REGS)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_rise(ev.addr_rise), .addr_in(ev.addr),
    .data_rise(ev.data_rise), .addr_q(addr_q), .addr_vld(addr_vld),
    .commit(commit)
  );

  param_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_file (
    .clk(clk), .rst_n(rst_n), .wr_en(commit),
    .wr_idx(addr_q[IDX_W-1:0]), .wr_data(ev.data), .regs(regs)
  );

  param_field_map #(.NUM_REGS(NUM_REGS)) u_map (
    .regs(regs), .rx_sync_chk(rx_sync_chk), .rx_sync_len(rx_sync_len),
    .ls_slew(ls_slew), .fsls_drv(fsls_drv)
  );

  a_r4_held_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[DEN_BIT] && den_lvl) |=> $stable(regs));
  a_r5_no_addr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> $stable(regs));
  a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && addr_q >= LIMIT) |=> $stable(regs));
  a_r7_both_rise_drops_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[AEN_BIT] && cfg_wdata[DEN_BIT] && !aen_lvl)
      |=> $stable(regs));
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(regs));
endmodule

// File: tb/tb_phy_param_port.sv
module tb_phy_param_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_sync_chk;
  logic [1:0]  rx_sync_len;
  logic        ls_slew, fsls_drv;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_reg [16];

  always #4 clk = ~clk;

  phy_param_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rx_sync_chk(rx_sync_chk), .rx_sync_len(rx_sync_len),
    .ls_slew(ls_slew), .fsls_drv(fsls_drv)
  );

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic addr_phase(input int a);
    wr(32'h1000_0000 | ((32'(a) & 32'hFFF) << 16));
    wr(32'h0);
  endtask

  task automatic data_phase(input logic [7:0] b);
    wr(32'h2000_0000 | (32'(b) << 16));
    wr(32'h0);
  endtask

  // R8 field map: entry0[5], entry1[1:0], entry10[6], entry10[5]
  task automatic check_out(input string tag);
    logic [4:0] act, expv;
    act  = {rx_sync_chk, rx_sync_len, ls_slew, fsls_drv};
    expv = {exp_reg[0][5], exp_reg[1][1:0], exp_reg[10][6], exp_reg[10][5]};
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 16; i++) exp_reg[i] = 8'h00;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 reset state");

    // R5: data before any address
    data_phase(8'hFF);
    check_out("R5 commit without address");

    // R2 R3 R6 R8 sweep
    for (int a = 0; a < 20; a++) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] b;
        case (k)
          0: b = 8'hFF;
          1: b = 8'h21;
          2: b = 8'h62;
          3: b = 8'h00;
          4: b = 8'h40;
          default: b = 8'(a * 37 + 5);
        endcase
        addr_phase(a);
        data_phase(b);
        if (a < 16) exp_reg[a] = b;
        check_out(a < 16 ? "R3 R8 commit sweep" : "R6 out of range ignored");
      end
    end

    // R9: one address, several commits
    addr_phase(10);
    data_phase(8'h40); exp_reg[10] = 8'h40; check_out("R9 first commit");
    data_phase(8'h20); exp_reg[10] = 8'h20; check_out("R9 second commit");
    data_phase(8'h60); exp_reg[10] = 8'h60; check_out("R9 third commit");

    // R4: data enable held high on a second write
    addr_phase(0);
    wr(32'h2000_0000 | (32'h20 << 16)); exp_reg[0] = 8'h20;
    wr(32'h2000_0000);
    check_out("R4 held data enable");
    wr(32'h0);
    wr(32'h1000_0000 | (32'd1 << 16));
    wr(32'h1000_0000 | (32'd10 << 16));
    wr(32'h0);
    data_phase(8'h03); exp_reg[1] = 8'h03;
    check_out("R4 held address enable");

    // R7: both enables rise together, address 1, byte 0x01 dropped
    addr_phase(0);
    data_phase(8'h00); exp_reg[0] = 8'h00;
    exp_reg[1] = 8'h00;
    addr_phase(1);
    data_phase(8'h00);
    check_out("R7 setup");
    addr_phase(0);
    wr(32'h3000_0000 | (32'h001 << 16));
    check_out("R7 data dropped");
    wr(32'h0);
    data_phase(8'h02); exp_reg[1] = 8'h02;
    check_out("R7 address latched");

    // R10: idle bus activity with strobe low
    @(negedge clk); cfg_wdata = 32'h1000_0000 | (32'd10 << 16);
    @(negedge clk); cfg_wdata = 32'h3000_0000 | (32'h0FF << 16);
    @(negedge clk); cfg_wdata = 32'h0;
    check_out("R10 idle bus ignored");
    data_phase(8'h61); exp_reg[1] = 8'h61;
    check_out("R10 address kept across idle");
    @(negedge clk); cfg_wdata = 32'h2000_0000;
    @(negedge clk);
    wr(32'h2000_0000 | (32'h03 << 16)); exp_reg[1] = 8'h03;
    wr(32'h0);
    check_out("R10 edge taken from written word");

    // R1 again: reset mid-run, then R5 after reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    clear_model();
    @(negedge clk);
    check_out("R1 reset clears entries");
    data_phase(8'hFF);
    check_out("R5 no address after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule